// File: doc/BRIEF.md
# Power Management Control and Status Register

This block holds the 16-bit power management control/status word of a bus function, together with the logic that reacts to writes of that word. The host side writes and reads the word through a plain write strobe and data port. The device side has a strobe that raises a wake event. It also has a write-one-to-clear port for its own sticky flags, and a mask that gates each flag's interrupt line.

The word has three fields. One is an event-present flag that the host can only clear. One is an event enable bit that lets the active-low event pin assert. The last is a two-bit power state that accepts only the fully-on and deepest-sleep codes. Host writes have side effects on the device side. Setting the enable bit, changing the power state and clearing a pending event each latch a separate sticky flag, and each flag can raise an interrupt toward local firmware.

Top module: `pm_power_csr`

## Requirements
- R1: While reset is held and after it is released, `host_rd_data` reads 0x0000, `evt_out_n` is 1, and `loc_flags`, `loc_irq` and `loc_pstate` are all 0.
- R2: Bits 14:9 and 7:2 of `host_rd_data` always read 0, whatever value the host writes to them.
- R3: Bit 15 (event status) becomes 1 on the clock after `loc_raise` is high. A host write with bit 15 set clears it. A host write with bit 15 at 0 leaves it unchanged.
- R4: When `loc_raise` and a host write of 1 to bit 15 occur in the same cycle, the status bit ends at 1 and no event-cleared flag is set.
- R5: Bit 8 (event enable) takes the written value on every host write. `evt_out_n` is 0 exactly when the enable bit and the status bit are both 1.
- R6: A host write with bit 8 at 1 sets sticky flag bit 0 (enable-set).
- R7: Bits 1:0 hold the power state (00 = D0, 11 = D3hot). A write of 00 or 11 is stored. A write of 01 or 10 is ignored and the old value is kept.
- R8: A host write that stores a power state different from the current one sets sticky flag bit 1 (state-changed). Rewriting the same value, or writing an ignored code, does not set it.
- R9: A host write that takes the status bit from 1 to 0 sets sticky flag bit 2 (event-cleared).
- R10: Sticky flags stay set until a `loc_clr_wr` cycle with the matching `loc_clr_data` bit at 1. If a flag is set and cleared in the same cycle, the set wins.
- R11: `loc_irq[i]` equals `loc_flags[i]` AND `loc_irq_mask[i]` in every cycle.
- R12: `loc_pstate` always equals bits 1:0 of `host_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| host_wr | input | 1 | Host write strobe for the register |
| host_wr_data | input | 16 | Host write data |
| host_rd_data | output | 16 | Current register value |
| loc_raise | input | 1 | Device-side strobe that sets the event status bit |
| loc_clr_wr | input | 1 | Device-side strobe to clear sticky flags |
| loc_clr_data | input | 3 | Write-one-to-clear mask for sticky flags |
| loc_irq_mask | input | 3 | Per-flag interrupt enable |
| evt_out_n | output | 1 | Active-low event output |
| loc_flags | output | 3 | Sticky flags: bit 0 enable-set, bit 1 state-changed, bit 2 event-cleared |
| loc_irq | output | 3 | Masked interrupt requests, one per flag |
| loc_pstate | output | 2 | Power state as seen by the device side |

## Verification
Two pairs of actions can land on the same edge. The first pair is a device-side raise and a host clear of the event status bit. The second pair is a flag being set by a host write while local firmware clears that same flag. The bench drives each pair in a single cycle and expects the set to win in both: the status reads 1 with no event-cleared flag, or the flag stays latched. Every power-state transition from each legal state to all four codes is swept. The enable/status combinations that decide the event pin, and all eight interrupt masks, are swept as well. Expected values come from a bench model of the requirements.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int REG_W      = 16;
  localparam int STAT_BIT   = 15;
  localparam int EN_BIT     = 8;
  localparam int PS_LSB     = 0;
  localparam int PS_W       = 2;
  localparam int NUM_FLAGS  = 3;
  localparam int FLG_EN_SET = 0;
  localparam int FLG_PS_CHG = 1;
  localparam int FLG_EV_CLR = 2;

  typedef enum logic [PS_W-1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  function automatic logic ps_legal(input logic [PS_W-1:0] v);
    return (v == PS_D0) || (v == PS_D3HOT);
  endfunction
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pm_csr_fields.sv
module pm_csr_fields
  import pm_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 wr_stat,
  input  logic                 wr_en,
  input  logic [PS_W-1:0]      wr_ps,
  input  logic                 loc_raise,
  output logic                 status_q,
  output logic                 enable_q,
  output logic [PS_W-1:0]      pstate_q,
  output logic [NUM_FLAGS-1:0] set_pulse
);
  logic            status_d, enable_d;
  logic [PS_W-1:0] pstate_d;
  logic            ps_take, host_clr;

  always_comb begin
    host_clr = host_wr && wr_stat;
    ps_take  = host_wr && ps_legal(wr_ps);

    status_d = status_q;
    if (loc_raise)     status_d = 1'b1;
    else if (host_clr) status_d = 1'b0;

    enable_d = host_wr ? wr_en : enable_q;
    pstate_d = ps_take ? wr_ps : pstate_q;

    set_pulse             = '0;
    set_pulse[FLG_EN_SET] = host_wr && wr_en;
    set_pulse[FLG_PS_CHG] = ps_take && (wr_ps != pstate_q);
    set_pulse[FLG_EV_CLR] = status_q && host_clr && !loc_raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      enable_q <= 1'b0;
      pstate_q <= PS_D0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      pstate_q <= pstate_d;
    end
  end

  p_raise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_raise |=> status_q);

  p_w0_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_raise && !(host_wr && wr_stat)) |=> $stable(status_q));

  p_bad_ps_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ps_legal(wr_ps)) |=> $stable(pstate_q));
endmodule

// File: rtl/pm_sticky_flags.sv
module pm_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_data,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d, clr_hit;

    always_comb begin
      clr_hit = clr_wr && clr_data[i];
      flag_d  = set_i[i] || (flags_q[i] && !clr_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flag_d;
    end

    assign irq_o[i] = flags_q[i] && mask[i];

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_hit) |=> flags_q[i]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_q[i]);
  end
endmodule

// File: rtl/pm_power_csr.sv
module pm_power_csr
  import pm_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [REG_W-1:0]     host_wr_data,
  output logic [REG_W-1:0]     host_rd_data,
  input  logic                 loc_raise,
  input  logic                 loc_clr_wr,
  input  logic [NUM_FLAGS-1:0] loc_clr_data,
  input  logic [NUM_FLAGS-1:0] loc_irq_mask,
  output logic                 evt_out_n,
  output logic [NUM_FLAGS-1:0] loc_flags,
  output logic [NUM_FLAGS-1:0] loc_irq,
  output logic [PS_W-1:0]      loc_pstate
);
  logic                 rst_int_n;
  logic                 status_q, enable_q;
  logic [PS_W-1:0]      pstate_q;
  logic [NUM_FLAGS-1:0] set_pulse;
  logic                 unused_rsvd;

  assign unused_rsvd = ^{host_wr_data[STAT_BIT-1:EN_BIT+1],
                         host_wr_data[EN_BIT-1:PS_LSB+PS_W]};

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  pm_csr_fields u_fields (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .host_wr   (host_wr),
    .wr_stat   (host_wr_data[STAT_BIT]),
    .wr_en     (host_wr_data[EN_BIT]),
    .wr_ps     (host_wr_data[PS_LSB +: PS_W]),
    .loc_raise (loc_raise),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .pstate_q  (pstate_q),
    .set_pulse (set_pulse)
  );

  pm_sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_i    (set_pulse),
    .clr_wr   (loc_clr_wr),
    .clr_data (loc_clr_data),
    .mask     (loc_irq_mask),
    .flags_q  (loc_flags),
    .irq_o    (loc_irq)
  );

  always_comb begin
    host_rd_data                  = '0;
    host_rd_data[STAT_BIT]        = status_q;
    host_rd_data[EN_BIT]          = enable_q;
    host_rd_data[PS_LSB +: PS_W]  = pstate_q;
  end

  assign evt_out_n  = !(status_q && enable_q);
  assign loc_pstate = pstate_q;

  p_ps_change_flag_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pstate_q != $past(pstate_q)) |-> loc_flags[FLG_PS_CHG]);

  p_evt_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !evt_out_n |-> (host_rd_data[EN_BIT] && host_rd_data[STAT_BIT]));
endmodule

// File: tb/pm_power_csr_tb_top.sv
module pm_power_csr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [15:0] host_wr_data;
  logic [15:0] host_rd_data;
  logic        loc_raise, loc_clr_wr;
  logic [2:0]  loc_clr_data, loc_irq_mask;
  logic        evt_out_n;
  logic [2:0]  loc_flags, loc_irq;
  logic [1:0]  loc_pstate;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic       m_st, m_en;
  logic [1:0] m_ps;
  logic [2:0] m_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_power_csr dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .loc_raise(loc_raise), .loc_clr_wr(loc_clr_wr),
    .loc_clr_data(loc_clr_data), .loc_irq_mask(loc_irq_mask), .evt_out_n(evt_out_n),
    .loc_flags(loc_flags), .loc_irq(loc_irq), .loc_pstate(loc_pstate)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [15:0] exp_rd;
    exp_rd = {m_st, 6'b0, m_en, 6'b0, m_ps};
    chk(tag, "rd_data", host_rd_data, exp_rd);
    chk({tag, "/R5"}, "evt_out_n", {15'b0, evt_out_n}, {15'b0, !(m_st && m_en)});
    chk(tag, "flags", {13'b0, loc_flags}, {13'b0, m_fl});
    chk({tag, "/R11"}, "irq", {13'b0, loc_irq}, {13'b0, m_fl & loc_irq_mask});
    chk({tag, "/R12"}, "pstate", {14'b0, loc_pstate}, {14'b0, m_ps});
  endtask

  task automatic step(input logic hw, input logic [15:0] hd, input logic raise,
                      input logic cw, input logic [2:0] cd, input string tag);
    logic       acc, n_st;
    logic [2:0] setv;
    @(negedge clk);
    host_wr = hw; host_wr_data = hd; loc_raise = raise;
    loc_clr_wr = cw; loc_clr_data = cd;
    @(posedge clk);
    #1;
    acc     = hw && (hd[1:0] == 2'b00 || hd[1:0] == 2'b11);
    setv[0] = hw && hd[8];
    setv[1] = acc && (hd[1:0] != m_ps);
    setv[2] = m_st && !raise && hw && hd[15];
    n_st    = raise ? 1'b1 : ((hw && hd[15]) ? 1'b0 : m_st);
    m_st    = n_st;
    if (hw)  m_en = hd[8];
    if (acc) m_ps = hd[1:0];
    m_fl    = setv | (m_fl & ~(cw ? cd : 3'b000));
    check_all(tag);
    host_wr = 1'b0; loc_raise = 1'b0; loc_clr_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_wr_data = '0; loc_raise = 1'b0;
    loc_clr_wr = 1'b0; loc_clr_data = '0; loc_irq_mask = 3'b111;
    m_st = 0; m_en = 0; m_ps = 0; m_fl = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // R2: reserved bits written high read back zero
    step(1, 16'h7EFC, 0, 0, 3'b000, "R2");
    step(1, 16'h7FFF, 0, 0, 3'b000, "R2");
    step(1, 16'h0000, 0, 1, 3'b111, "R2");

    // R3 / R9: raise, write zero keeps, write one clears and flags
    step(0, 16'h0000, 1, 0, 3'b000, "R3");
    step(1, 16'h0000, 0, 0, 3'b000, "R3");
    step(1, 16'h8000, 0, 0, 3'b000, "R9");
    step(1, 16'h8000, 0, 1, 3'b100, "R3");

    // R4: raise and host clear collide
    step(0, 16'h0000, 1, 0, 3'b000, "R4");
    step(1, 16'h8000, 1, 0, 3'b000, "R4");
    step(1, 16'h8000, 0, 1, 3'b111, "R9");

    // R5 / R6: enable and status combinations decide the pin
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        step(1, {1'b1, 6'b0, e[0], 8'h00}, 0, 1, 3'b111, "R6");
        if (s != 0) step(0, 16'h0000, 1, 0, 3'b000, "R5");
        step(0, 16'h0000, 0, 0, 3'b000, "R5");
      end
    end

    // R7 / R8: every code written from each legal state
    for (int f = 0; f < 2; f++) begin
      for (int t = 0; t < 4; t++) begin
        step(1, {14'b0, (f != 0) ? 2'b11 : 2'b00}, 0, 0, 3'b000, "R7");
        step(0, 16'h0000, 0, 1, 3'b111, "R10");
        step(1, {14'b0, t[1:0]}, 0, 0, 3'b000, "R8");
      end
    end

    // R10: set and clear of the same flag in one cycle
    step(1, 16'h0100, 0, 1, 3'b001, "R10");
    step(0, 16'h0000, 0, 1, 3'b010, "R10");
    step(0, 16'h0000, 0, 0, 3'b000, "R10");

    // R11: all masks with all flags set
    step(1, 16'h8000, 1, 0, 3'b000, "R11");
    step(1, 16'h8103, 0, 0, 3'b000, "R11");
    for (int m = 0; m < 8; m++) begin
      loc_irq_mask = m[2:0];
      step(0, 16'h0000, 0, 0, 3'b000, "R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule